// File: doc/BRIEF.md
# Sign-Gradient Step Error Tracker

This block closes the adaptation loop of a background calibration that removes the code jump between adjacent coarse segments of a two-stage converter. A separate measurement path reports an estimate of out-of-band (harmonic) power. That path raises a one-cycle strobe each time a fresh estimate is ready, which happens once per calibration period of four scan times. The tracker nudges a signed step-error value in the direction the gradient rule gives. The correction block downstream consumes that value.

On every strobe the block compares the new estimate with the one it kept from the previous strobe. It then moves the step-error value by one fixed increment: upward when the power rose, downward when it fell, and not at all when the two are equal. Only the sign of the difference is used. Once the loop has converged, the value settles into a small oscillation around the power minimum. A hold input freezes the value while the comparison history keeps following the incoming estimates.

Top module: `sign_grad_step_tracker`

## Requirements
- R1: While reset is asserted and after its release, `stepOut` is zero until an update takes place.
- R2: The first `powerValid` strobe after reset only captures the estimate as the reference and leaves `stepOut` unchanged.
- R3: On a later strobe whose `powerIn` is greater than the stored reference, `stepOut` rises by one raw unit in the cycle after the strobe.
- R4: On a later strobe whose `powerIn` is less than the stored reference, `stepOut` falls by one raw unit in the cycle after the strobe.
- R5: On a later strobe whose `powerIn` equals the stored reference, `stepOut` stays unchanged.
- R6: In cycles without `powerValid`, `stepOut` stays unchanged whatever `powerIn` does.
- R7: While `hold` is high, strobes do not change `stepOut`, but each of them still replaces the stored reference with its `powerIn`.
- R8: `stepOut` saturates at +2047 and -2048 and never wraps.
- R9: `stepOut` is 12-bit two's complement with 5 fractional bits, so one raw unit is 1/32 LSB and 32 rises amount to a value of 32 (one full LSB).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerIn | input | 16 | Unsigned harmonic power estimate |
| powerValid | input | 1 | One-cycle strobe marking a new estimate |
| hold | input | 1 | Freezes the step-error value |
| stepOut | output | 12 | Signed step-error value, 1/32 LSB per unit |

## Verification
The bench sweeps every ordered pair drawn from a small set of power values. This exercises rise, fall and tie. A design that treated a tie as a rise would creep steadily in one direction. A design with an inverted comparator would walk away from the minimum. It then drives the value into both rails with long monotonic runs: a design without saturation would wrap from +2047 to -2048 and cause a full-scale code jump. Held strobes are followed by a strobe that repeats the last held power. A tracker that dropped the reference update during hold would then make a spurious move. A reset in the middle of the run checks that the first strobe afterwards re-arms the tracker rather than comparing against a stale reference.

// File: rtl/step_trk_pkg.sv
package step_trk_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic loadRef;   // capture powerIn as the new reference
    logic incStep;   // raise the step-error value by one increment
    logic decStep;   // lower the step-error value by one increment
  } trk_ctrl_t;

endpackage

// File: rtl/step_trk_ctrl.sv
module step_trk_ctrl
  import step_trk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      powerValid,
  input  logic      hold,
  input  logic      cmpGt,
  input  logic      cmpLt,
  output trk_ctrl_t ctrl
);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN)           armed <= 1'b0;
    else if (powerValid) armed <= 1'b1;
  end

  always_comb begin
    ctrl.loadRef = powerValid;
    ctrl.incStep = powerValid && armed && !hold && cmpGt;
    ctrl.decStep = powerValid && armed && !hold && cmpLt;
  end

  // R2
  unarmed_no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !(ctrl.incStep || ctrl.decStep));

  // R7
  hold_no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> !(ctrl.incStep || ctrl.decStep));

  // R6
  idle_no_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerValid |-> !(ctrl.incStep || ctrl.decStep));

  // R5
  single_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.incStep, ctrl.decStep}));

endmodule

// File: rtl/step_trk_dp.sv
module step_trk_dp
  import step_trk_pkg::*;
#(
  parameter int POWER_W  = 16,
  parameter int STEP_W   = 12,
  parameter int STEP_INC = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [POWER_W-1:0]       powerIn,
  input  trk_ctrl_t                ctrl,
  output logic                     cmpGt,
  output logic                     cmpLt,
  output logic signed [STEP_W-1:0] stepVal
);

  localparam int EXT_W = STEP_W + 1;
  localparam logic signed [EXT_W-1:0] INC_EXT = EXT_W'(STEP_INC);
  localparam logic signed [EXT_W-1:0] MAX_EXT = EXT_W'((1 << (STEP_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_EXT = -EXT_W'(1 << (STEP_W - 1));

  logic [POWER_W-1:0]       refPower;
  logic signed [EXT_W-1:0]  stepExt;
  logic signed [EXT_W-1:0]  upSum;
  logic signed [EXT_W-1:0]  downSum;
  logic signed [STEP_W-1:0] stepNext;

  // Sign of the power difference
  assign cmpGt = powerIn > refPower;
  assign cmpLt = powerIn < refPower;

  always_ff @(posedge clk) begin
    if (!rstN)             refPower <= '0;
    else if (ctrl.loadRef) refPower <= powerIn;
  end

  assign stepExt = {stepVal[STEP_W-1], stepVal};
  assign upSum   = stepExt + INC_EXT;
  assign downSum = stepExt - INC_EXT;

  always_comb begin
    stepNext = stepVal;
    if (ctrl.incStep)
      stepNext = (upSum > MAX_EXT) ? STEP_W'(MAX_EXT) : upSum[STEP_W-1:0];
    else if (ctrl.decStep)
      stepNext = (downSum < MIN_EXT) ? STEP_W'(MIN_EXT) : downSum[STEP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) stepVal <= '0;
    else       stepVal <= stepNext;
  end

  // R6
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.incStep || ctrl.decStep) |=> $stable(stepVal));

  // R3
  rise_amount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.incStep && (stepExt <= MAX_EXT - INC_EXT))
      |=> (stepVal == $past(stepVal) + STEP_W'(STEP_INC)));

  // R4
  fall_amount_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.decStep && (stepExt >= MIN_EXT + INC_EXT))
      |=> (stepVal == $past(stepVal) - STEP_W'(STEP_INC)));

  // R8
  top_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.incStep && (stepExt > MAX_EXT - INC_EXT))
      |=> (stepVal == STEP_W'(MAX_EXT)));

  // R8
  bottom_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.decStep && (stepExt < MIN_EXT + INC_EXT))
      |=> (stepVal == STEP_W'(MIN_EXT)));

endmodule

// File: rtl/sign_grad_step_tracker.sv
module sign_grad_step_tracker
  import step_trk_pkg::*;
#(
  parameter int POWER_W  = 16,
  parameter int STEP_W   = 12,
  parameter int STEP_INC = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [POWER_W-1:0]       powerIn,
  input  logic                     powerValid,
  input  logic                     hold,
  output logic signed [STEP_W-1:0] stepOut
);

  trk_ctrl_t ctrl;
  logic      cmpGt;
  logic      cmpLt;

  step_trk_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .powerValid (powerValid),
    .hold       (hold),
    .cmpGt      (cmpGt),
    .cmpLt      (cmpLt),
    .ctrl       (ctrl)
  );

  step_trk_dp #(
    .POWER_W  (POWER_W),
    .STEP_W   (STEP_W),
    .STEP_INC (STEP_INC)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .powerIn (powerIn),
    .ctrl    (ctrl),
    .cmpGt   (cmpGt),
    .cmpLt   (cmpLt),
    .stepVal (stepOut)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (stepOut == '0));

endmodule

// File: tb/sign_grad_step_tracker_tb_top.sv
module sign_grad_step_tracker_tb_top;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [15:0]        powerIn = '0;
  logic               powerValid = 1'b0;
  logic               hold = 1'b0;
  logic signed [11:0] stepOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model
  int  expStep = 0;
  bit  armed = 1'b0;
  int  refP = 0;

  always #2ns clk = ~clk;

  sign_grad_step_tracker dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .powerIn    (powerIn),
    .powerValid (powerValid),
    .hold       (hold),
    .stepOut    (stepOut)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: stepOut=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0; powerValid = 1'b0; hold = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expStep = 0; armed = 1'b0; refP = 0;
  endtask

  // One strobe; check the cycle after the capturing edge
  task automatic strobe(int p, bit h);
    string req;
    @(negedge clk);
    powerIn = 16'(p); powerValid = 1'b1; hold = h;
    if (!armed) begin
      req = "R2"; armed = 1'b1;
    end else if (h) begin
      req = "R7";
    end else if (p > refP) begin
      req = (expStep == 2047) ? "R8" : "R3";
      if (expStep < 2047) expStep++;
    end else if (p < refP) begin
      req = (expStep == -2048) ? "R8" : "R4";
      if (expStep > -2048) expStep--;
    end else begin
      req = "R5";
    end
    refP = p;
    @(negedge clk);
    powerValid = 1'b0; hold = 1'b0;
    chk(req, int'(stepOut), expStep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: stepOut=%0d expected run to end", int'(stepOut));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: held in reset and right after release
    @(negedge clk);
    chk("R1", int'(stepOut), 0);
    do_reset();
    @(negedge clk);
    chk("R1", int'(stepOut), 0);

    // R2: first strobe only captures
    strobe(100, 1'b0);
    chk("R2", int'(stepOut), 0);

    // Ordered-pair sweep covering R3, R4, R5
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        strobe(a * 37, 1'b0);
        strobe(b * 37, 1'b0);
      end
    end

    // R7: held strobes move nothing but update the reference
    strobe(500, 1'b0);
    strobe(900, 1'b1);
    strobe(50, 1'b1);
    strobe(700, 1'b1);
    strobe(700, 1'b0);   // equal to last held value: no move
    chk("R7", int'(stepOut), expStep);

    // R6: idle cycles with a moving powerIn
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      powerIn = 16'(i * 3001);
      chk("R6", int'(stepOut), expStep);
    end

    // R9: 32 rises from zero equal one full LSB (32 raw units)
    do_reset();
    strobe(10, 1'b0);
    for (int i = 0; i < 32; i++) strobe(11 + i, 1'b0);
    chk("R9", int'(stepOut), 32);

    // R8: run into the upper rail and stay there
    for (int i = 0; i < 2100; i++) strobe(100 + i, 1'b0);
    chk("R8", int'(stepOut), 2047);

    // R8: run into the lower rail and stay there
    for (int i = 0; i < 4200; i++) strobe(60000 - i, 1'b0);
    chk("R8", int'(stepOut), -2048);

    // R2: reset mid-run, then the first strobe must not move the value
    do_reset();
    @(negedge clk);
    chk("R1", int'(stepOut), 0);
    strobe(0, 1'b0);
    chk("R2", int'(stepOut), 0);
    strobe(1, 1'b0);
    chk("R3", int'(stepOut), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule